// File: doc/BRIEF.md
# Serial ADC Command Framing Interface

This block is the device-side digital end of a serial link to a multi-channel 8-bit converter whose host supplies the conversion clock. It watches an active-low chip select, a serial clock and a data-in line. It hunts for a start bit and assembles an 8-bit command from it. When the command is complete it raises a one-cycle conversion request that carries the seven command bits after the start bit. The result word comes back on a parallel sample port, and the block shifts it out MSB first on data-out.

Start detection is level based: the first high bit seen on data-in starts a command. Detection re-arms as soon as the MSB of the running result has been driven. This lets the next command be clocked in while the present result is still leaving, so conversions can follow each other every 10 serial clocks. Hosts that work in whole bytes can run at 16 clocks per conversion. All three serial lines are sampled by the block clock `clk`, and edges are found by comparing each line with its registered copy.

Top module: `sadc_frame_if`

## Requirements
- R1: A falling edge on `cs_n` neither starts a command nor raises `conv_req`. Low bits on `din` while the interface is idle are ignored.
- R2: With `cs_n` low and the interface idle (including after reset), the first rising serial-clock edge that samples `din` = 1 is the start bit, and it becomes command bit 7.
- R3: The seven bits sampled on the next seven rising edges fill `conv_ctrl[6:0]`, first bit in bit 6. On the falling edge that follows the eighth rising edge, `conv_req` goes high, and `conv_ctrl` holds those bits while `conv_req` is high.
- R4: After a command is taken, high bits on `din` are not start bits until the result MSB has been driven. The first rising edge after that falling edge may start a new command.
- R5: `dout` changes only after serial-clock falling edges. Counting the request edge as F, `dout` is low after F and F+1, carries B7..B0 after F+2..F+9, and is low again after F+10 until the next result.
- R6: Raising `cs_n` while a result is pending (from the request up to the edge that ends B0) pulses `conv_abort` for one cycle. Raising `cs_n` clears all framing state and drives `dout` low. With `cs_n` low again, the next high `din` bit is a start bit.
- R7: Commands sent every 10 serial clocks produce one request and one full result per command, back to back.
- R8: Commands sent every 16 serial clocks produce one request and one full result per command.
- R9: `dout_oe` is low whenever `cs_n` is high and high whenever it is low. After reset, `dout` is low.
- R10: `conv_req` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all lines are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial command data, sampled on serial-clock rising edges |
| smp_valid | input | 1 | Converter stub has placed a result on `smp_data` |
| smp_data | input | 8 | Parallel result word from the converter stub |
| dout | output | 1 | Serial result data, MSB first |
| dout_oe | output | 1 | Drive enable for `dout` |
| conv_req | output | 1 | One-cycle conversion request |
| conv_ctrl | output | 7 | Channel, mode and power bits of the command |
| conv_abort | output | 1 | One-cycle pulse when a pending conversion is cancelled |

## Verification
At 10 clocks per conversion, two functions share one moment. The start bit of the next command is sampled on the rising edge right after B7 of the current result is driven. The falling edge that ends the old result's B0 is also the edge that issues the new request. Back-to-back 10-clock frames provoke both, and some frames put high junk bits into the two clocks where detection is still closed. The bench builds a schedule of expected `dout` values and request edges from each start bit it sends. It compares `dout` on every serial cycle and checks every request for both its edge and its command bits, so any slip in re-arming or any collision in shift-out shows as a mismatch.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    localparam int SADC_RES_W = 8;
    localparam int SADC_CMD_W = 8;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_CAPT = 2'd1,
        RX_FULL = 2'd2,
        RX_BUSY = 2'd3
    } rx_state_t;

    typedef struct packed {
        logic rise;
        logic fall;
        logic cs_rise;
    } sclk_evt_t;

endpackage

// File: rtl/sadc_edge_det.sv
module sadc_edge_det
    import sadc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cs_n,
    input  logic      sclk,
    output sclk_evt_t evt
);
    logic sclk_q;
    logic cs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
        end else begin
            sclk_q <= sclk;
            cs_q   <= cs_n;
        end
    end

    always_comb begin
        evt.rise    = sclk & ~sclk_q & ~cs_n;
        evt.fall    = ~sclk & sclk_q & ~cs_n;
        evt.cs_rise = cs_n & ~cs_q;
    end
endmodule

// File: rtl/sadc_cmd_rx.sv
module sadc_cmd_rx
    import sadc_pkg::*;
#(
    parameter int CMD_W = SADC_CMD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             rise,
    input  logic             fall,
    input  logic             din,
    input  logic             rearm,
    output logic             req,
    output logic [CMD_W-2:0] ctrl
);
    localparam int CNT_W = $clog2(CMD_W + 1);

    rx_state_t        st;
    logic [CNT_W-1:0] cnt;
    logic [CMD_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (!clr && st == RX_FULL && fall) begin
            ctrl <= sh[CMD_W-2:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            st  <= RX_IDLE;
            cnt <= '0;
            sh  <= '0;
            req <= 1'b0;
        end else begin
            req <= 1'b0;
            case (st)
                RX_IDLE: if (rise && din) begin
                    st  <= RX_CAPT;
                    cnt <= CNT_W'(1);
                    sh  <= CMD_W'(1);
                end
                RX_CAPT: if (rise) begin
                    sh  <= {sh[CMD_W-2:0], din};
                    cnt <= cnt + 1'b1;
                    if (cnt == CNT_W'(CMD_W - 1)) st <= RX_FULL;
                end
                RX_FULL: if (fall) begin
                    req <= 1'b1;
                    st  <= RX_BUSY;
                end
                RX_BUSY: if (rearm) st <= RX_IDLE;
                default: st <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sadc_res_tx.sv
module sadc_res_tx
    import sadc_pkg::*;
#(
    parameter int RES_W = SADC_RES_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             fall,
    input  logic             req,
    input  logic             smp_valid,
    input  logic [RES_W-1:0] smp_data,
    output logic             dout,
    output logic             rearm,
    output logic             busy
);
    localparam int LAST  = RES_W + 2;
    localparam int OCW   = $clog2(LAST + 1);

    logic [RES_W-1:0] res;
    logic [RES_W-1:0] sh;
    logic [OCW-1:0]   ocnt;

    always_ff @(posedge clk) begin
        if (rst) res <= '0;
        else if (smp_valid) res <= smp_data;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ocnt <= '0;
            dout <= 1'b0;
            sh   <= '0;
        end else if (req) begin
            ocnt <= OCW'(1);
        end else if (fall && ocnt != '0) begin
            if (ocnt == OCW'(1)) begin
                dout <= 1'b0;
                ocnt <= OCW'(2);
            end else if (ocnt == OCW'(2)) begin
                dout <= res[RES_W-1];
                sh   <= {res[RES_W-2:0], 1'b0};
                ocnt <= OCW'(3);
            end else if (ocnt == OCW'(LAST)) begin
                dout <= 1'b0;
                ocnt <= '0;
            end else begin
                dout <= sh[RES_W-1];
                sh   <= {sh[RES_W-2:0], 1'b0};
                ocnt <= ocnt + 1'b1;
            end
        end
    end

    assign rearm = fall && !clr && (ocnt == OCW'(2));
    assign busy  = (ocnt != '0);
endmodule

// File: rtl/sadc_frame_if.sv
module sadc_frame_if
    import sadc_pkg::*;
#(
    parameter int RES_W = SADC_RES_W,
    parameter int CMD_W = SADC_CMD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             din,
    input  logic             smp_valid,
    input  logic [RES_W-1:0] smp_data,
    output logic             dout,
    output logic             dout_oe,
    output logic             conv_req,
    output logic [CMD_W-2:0] conv_ctrl,
    output logic             conv_abort
);
    sclk_evt_t evt;
    logic      rearm;
    logic      busy;

    sadc_edge_det u_edge (
        .clk  (clk),
        .rst  (rst),
        .cs_n (cs_n),
        .sclk (sclk),
        .evt  (evt)
    );

    sadc_cmd_rx #(.CMD_W(CMD_W)) u_rx (
        .clk   (clk),
        .rst   (rst),
        .clr   (cs_n),
        .rise  (evt.rise),
        .fall  (evt.fall),
        .din   (din),
        .rearm (rearm),
        .req   (conv_req),
        .ctrl  (conv_ctrl)
    );

    sadc_res_tx #(.RES_W(RES_W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .clr       (cs_n),
        .fall      (evt.fall),
        .req       (conv_req),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .dout      (dout),
        .rearm     (rearm),
        .busy      (busy)
    );

    always_ff @(posedge clk) begin
        if (rst) conv_abort <= 1'b0;
        else     conv_abort <= evt.cs_rise && busy;
    end

    assign dout_oe = ~cs_n;
endmodule

// File: rtl/sadc_frame_if_chk.sv
module sadc_frame_if_chk (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic sclk,
    input logic dout,
    input logic conv_req,
    input logic conv_abort
);
    // R1: a chip-select falling edge raises no request on the next cycle
    p_no_req_on_cs_fall_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |=> !conv_req);

    // R5 and R9: dout moves only after a serial-clock fall or on deselect
    p_dout_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(dout) |-> ($past(cs_n) || ($past(sclk, 2) && !$past(sclk))));

    // R9: deselected interface keeps dout low
    p_dout_low_deselect_r9: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n)) |-> !dout);

    // R6: abort only follows a chip-select rising edge
    p_abort_on_cs_rise_r6: assert property (@(posedge clk) disable iff (rst)
        conv_abort |-> ($past(cs_n) && !$past(cs_n, 2)));

    // R10: request is a single-cycle pulse
    p_req_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        conv_req |=> !conv_req);
endmodule

bind sadc_frame_if sadc_frame_if_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .sclk       (sclk),
    .dout       (dout),
    .conv_req   (conv_req),
    .conv_abort (conv_abort)
);

// File: tb/sim_sadc_frame_if.sv
module sim_sadc_frame_if;
    localparam int H = 4;
    localparam int INF = 1 << 30;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       din = 1'b0;
    logic       smp_valid = 1'b0;
    logic [7:0] smp_data = 8'h00;
    logic       dout, dout_oe, conv_req, conv_abort;
    logic [6:0] conv_ctrl;

    always #10 clk = ~clk;

    sadc_frame_if u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
        .smp_valid(smp_valid), .smp_data(smp_data), .dout(dout),
        .dout_oe(dout_oe), .conv_req(conv_req), .conv_ctrl(conv_ctrl),
        .conv_abort(conv_abort)
    );

    function automatic logic [7:0] res_of(input logic [6:0] c, input int n);
        logic [7:0] m;
        m = 8'(n * 29 + 7);
        return {c, 1'b1} ^ m;
    endfunction

    // converter stub
    int nstub = 0;
    always @(posedge clk) begin
        smp_valid <= conv_req;
        if (conv_req) begin
            smp_data <= res_of(conv_ctrl, nstub);
            nstub    <= nstub + 1;
        end
    end

    int tests = 0, fails = 0;
    int k = 0;
    int cap_left = 0, armed_from = 0, nreq = 0, last_req_fall = -100;
    logic [7:0] cbyte = 8'h00;
    bit req_pend = 0;
    logic exp_out [0:4095];
    string tag = "R2";
    int got_ctrl[$], got_k[$];
    int abort_cnt = 0, exp_abort = 0, dbl_req = 0;
    logic prev_req = 1'b0;

    always @(negedge clk) begin
        if (conv_req) begin
            got_ctrl.push_back(int'(conv_ctrl));
            got_k.push_back(k);
        end
        if (conv_abort) abort_cnt++;
        if (conv_req && prev_req) dbl_req++;
        prev_req = conv_req;
    end

    task automatic check(input bit ok, input string r, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", r, act, exp, k);
        end
    endtask

    task automatic sclk_cycle(input logic d);
        @(negedge clk);
        din = d;
        check(dout === exp_out[k], {tag, "/R5 dout"}, int'(dout), int'(exp_out[k]));
        k++;
        // model: rising edge k
        if (cap_left > 0) begin
            cbyte = {cbyte[6:0], d};
            cap_left--;
            if (cap_left == 0) req_pend = 1;
        end else if (k >= armed_from && d) begin
            cbyte = 8'h01;
            cap_left = 7;
            armed_from = INF;
        end
        @(negedge clk);
        sclk = 1'b1;
        repeat (H) @(negedge clk);
        sclk = 1'b0;
        repeat (H) @(negedge clk);
        // model: falling edge k
        if (req_pend) begin
            logic [7:0] r;
            r = res_of(cbyte[6:0], nreq);
            nreq++;
            exp_out[k + 1] = 1'b0;
            for (int i = 0; i < 8; i++) exp_out[k + 2 + i] = r[7 - i];
            exp_out[k + 10] = 1'b0;
            armed_from = k + 3;
            last_req_fall = k;
            req_pend = 0;
            check(got_ctrl.size() == 1, {tag, "/R3 request count"}, got_ctrl.size(), 1);
            if (got_ctrl.size() > 0) begin
                int gc, gk;
                gc = got_ctrl.pop_front();
                gk = got_k.pop_front();
                check(gc == int'(cbyte[6:0]), {tag, "/R3 ctrl"}, gc, int'(cbyte[6:0]));
                check(gk == k, {tag, "/R2 request edge"}, gk, k);
            end
        end else begin
            check(got_ctrl.size() == 0, {tag, "/R4 spurious request"}, got_ctrl.size(), 0);
            got_ctrl.delete();
            got_k.delete();
        end
    endtask

    task automatic frame(input logic [6:0] c, input int total, input logic junk);
        sclk_cycle(1'b1);
        for (int i = 6; i >= 0; i--) sclk_cycle(c[i]);
        for (int i = 8; i < total; i++) sclk_cycle((i < 10) ? junk : 1'b0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) sclk_cycle(1'b0);
    endtask

    task automatic cs_toggle;
        @(negedge clk);
        din = 1'b0;
        if (last_req_fall >= 0 && k < last_req_fall + 10) exp_abort++;
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
        check(dout_oe == 1'b0, "R9 oe while deselected", int'(dout_oe), 0);
        check(dout == 1'b0, "R6 dout cleared", int'(dout), 0);
        check(abort_cnt == exp_abort, "R6 abort pulses", abort_cnt, exp_abort);
        for (int i = k + 1; i < k + 24; i++) exp_out[i] = 1'b0;
        cap_left = 0;
        req_pend = 0;
        armed_from = k + 1;
        last_req_fall = -100;
        cs_n = 1'b0;
        repeat (3) @(negedge clk);
        check(conv_req == 1'b0 && got_ctrl.size() == 0, "R1 cs fall no request",
              got_ctrl.size(), 0);
        check(dout_oe == 1'b1, "R9 oe while selected", int'(dout_oe), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4096; i++) exp_out[i] = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(dout == 1'b0, "R9 reset dout", int'(dout), 0);
        check(dout_oe == 1'b0, "R9 reset oe", int'(dout_oe), 0);
        check(conv_req == 1'b0, "R10 reset req", int'(conv_req), 0);

        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        check(got_ctrl.size() == 0, "R1 cs fall alone", got_ctrl.size(), 0);
        check(dout_oe == 1'b1, "R9 oe selected", int'(dout_oe), 1);
        tag = "R1";
        idle(3);

        tag = "R8";
        frame(7'h2B, 16, 1'b0);
        frame(7'h55, 16, 1'b0);
        frame(7'h0F, 16, 1'b0);
        idle(6);

        tag = "R7";
        frame(7'h71, 10, 1'b0);
        frame(7'h12, 10, 1'b1);
        frame(7'h7F, 10, 1'b1);
        frame(7'h00, 10, 1'b0);
        idle(12);

        tag = "R6";
        frame(7'h44, 12, 1'b0);
        cs_toggle();
        frame(7'h19, 16, 1'b0);
        idle(4);
        sclk_cycle(1'b1);
        sclk_cycle(1'b0);
        sclk_cycle(1'b1);
        cs_toggle();
        frame(7'h66, 10, 1'b1);
        frame(7'h3C, 10, 1'b0);
        idle(12);

        check(nreq == nstub, "R7 requests seen", nstub, nreq);
        check(dbl_req == 0, "R10 single-cycle request", dbl_req, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule